// File: doc/BRIEF.md
# Tag-Matching Reservation Station Unit

This block is the operand-waiting stage in front of a single functional unit. It keeps a small pool of reservation stations and a table that records, for every architectural register, whether a result is still outstanding and which station will produce it. At issue, an operation takes the lowest free station. Each source operand is either copied as a value, when its register is settled, or recorded as the producing station's tag, when the register is still pending.

All stations snoop one result bus that carries a tag and a value. A waiting operand whose tag equals the broadcast tag takes the value. A station whose operands are both present offers itself to the functional unit. When several stations are ready, the lowest-numbered one goes first. A station stays allocated after dispatch and is released only when its own tag appears on the result bus. The same broadcast clears the busy bit of every register that still names that tag.

Top module: `rs_unit`

## Requirements
- R1: Station k (counting from 0) owns tag k+1. Tag value 0 means "operand present" and is never used by a station. The dispatch port reports the tag of the station being sent.
- R2: `issue_ready_o` is low while every station is allocated. An issue request made while it is low has no effect on any station or register status.
- R3: A source read from a register that is not busy is copied into the station as the value supplied on the issue port.
- R4: A source read from a busy register stores that register's producer tag. The station does not offer dispatch while any operand still holds a tag.
- R5: A waiting operand whose tag equals the tag on a valid result broadcast captures the broadcast value at that edge. The station may then dispatch from the next cycle.
- R6: When a result is broadcast in the same cycle as an issue that reads the producing register, the broadcast value goes directly into the new station. The new station never waits on that tag.
- R7: A station offers dispatch only when both operands are present. Once it has been accepted (`disp_valid_o` and `fu_ready_i` high together), it is not offered again.
- R8: Among ready stations, the lowest-numbered one is presented on the dispatch port. A newly issued operation takes the lowest-numbered free station.
- R9: A station is released at the edge where its own tag is broadcast, and it can be allocated again from the next cycle.
- R10: Issue sets the destination register's busy bit and records the new station tag. A broadcast clears a register's busy bit only when the register's recorded tag equals the broadcast tag. A register rewritten by a younger issue stays busy.
- R11: After reset, all stations are free, all registers are not busy, and `disp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_ready_o | output | 1 | A station is free; the request is accepted this cycle |
| issue_op_i | input | OP_W | Operation code carried to the functional unit |
| issue_dst_i | input | REG_W | Destination register |
| issue_src1_i | input | REG_W | First source register |
| issue_src2_i | input | REG_W | Second source register |
| issue_val1_i | input | DATA_W | Register file value of the first source |
| issue_val2_i | input | DATA_W | Register file value of the second source |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TAG_W | Tag of the station whose result is broadcast |
| cdb_value_i | input | DATA_W | Broadcast result value |
| fu_ready_i | input | 1 | Functional unit accepts a dispatch this cycle |
| disp_valid_o | output | 1 | A ready station is being offered |
| disp_tag_o | output | TAG_W | Tag of the offered station |
| disp_op_o | output | OP_W | Operation of the offered station |
| disp_a_o | output | DATA_W | First operand value |
| disp_b_o | output | DATA_W | Second operand value |
| reg_busy_o | output | NUM_REGS | Busy bit of each architectural register |

## Verification
Every cycle, the assertions check four things. No station is accepted while it holds a tag or has already been sent. No lower-numbered ready station is skipped. A station's own broadcast releases it. A register whose tag does not match the broadcast stays busy. They also check that captured operands carry exactly the broadcast value and that a refused issue leaves register status alone. Only the directed scenarios can show end-to-end values. These include the forwarded value in a same-cycle issue and broadcast, the dispatch order after a wake-up, reuse of a released station, and the full-pool stall seen at the ports.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DEF_NUM_RS   = 3;
  localparam int DEF_NUM_REGS = 8;
  localparam int DEF_DATA_W   = 16;
  localparam int DEF_OP_W     = 3;

  // tag 0 is reserved for "value present"
  function automatic int tag_bits(input int num_rs);
    return $clog2(num_rs + 1);
  endfunction

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // scan from the top so the lowest set bit is assigned last
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_tag_table.sv
module rs_tag_table #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 3,
  parameter int TAG_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_reg_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic                cdb_valid_i,
  input  logic [TAG_W-1:0]    cdb_tag_i,
  input  logic [REG_W-1:0]    rd1_i,
  input  logic [REG_W-1:0]    rd2_i,
  output logic                rd1_busy_o,
  output logic [TAG_W-1:0]    rd1_tag_o,
  output logic                rd2_busy_o,
  output logic [TAG_W-1:0]    rd2_tag_o,
  output logic [NUM_REGS-1:0] busy_o
);
  logic [NUM_REGS-1:0] busy_q;
  logic [TAG_W-1:0]    tag_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit_wr;
    logic hit_cdb;
    assign hit_wr  = wr_en_i && (wr_reg_i == REG_W'(r));
    assign hit_cdb = cdb_valid_i && busy_q[r] && (tag_q[r] == cdb_tag_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end else if (hit_wr) begin
        busy_q[r] <= 1'b1;
        tag_q[r]  <= wr_tag_i;
      end else if (hit_cdb) begin
        busy_q[r] <= 1'b0;
      end
    end

    // R10
    keep_busy_on_stale_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[r] && cdb_valid_i && (tag_q[r] != cdb_tag_i)) |=> busy_q[r]);
  end

  assign rd1_busy_o = busy_q[rd1_i];
  assign rd1_tag_o  = tag_q[rd1_i];
  assign rd2_busy_o = busy_q[rd2_i];
  assign rd2_tag_o  = tag_q[rd2_i];
  assign busy_o     = busy_q;
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int              DATA_W = 16,
  parameter int              OP_W   = 3,
  parameter int              TAG_W  = 2,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  s1_tag_i,
  input  logic [DATA_W-1:0] s1_val_i,
  input  logic [TAG_W-1:0]  s2_tag_i,
  input  logic [DATA_W-1:0] s2_val_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  input  logic              disp_go_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic              busy_q, sent_q;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  t1_q, t2_q;
  logic [DATA_W-1:0] v1_q, v2_q;
  logic              own_bcast, hit1, hit2;

  assign own_bcast = cdb_valid_i && (cdb_tag_i == MY_TAG);
  assign hit1      = cdb_valid_i && (t1_q != '0) && (t1_q == cdb_tag_i);
  assign hit2      = cdb_valid_i && (t2_q != '0) && (t2_q == cdb_tag_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      op_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      v1_q   <= '0;
      v2_q   <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
      op_q   <= op_i;
      t1_q   <= s1_tag_i;
      v1_q   <= s1_val_i;
      t2_q   <= s2_tag_i;
      v2_q   <= s2_val_i;
    end else if (busy_q) begin
      if (own_bcast) begin
        busy_q <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        if (disp_go_i) sent_q <= 1'b1;
        if (hit1) begin
          t1_q <= '0;
          v1_q <= cdb_val_i;
        end
        if (hit2) begin
          t2_q <= '0;
          v2_q <= cdb_val_i;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !sent_q && (t1_q == '0) && (t2_q == '0);
  assign op_o    = op_q;
  assign a_o     = v1_q;
  assign b_o     = v2_q;

  // R7
  send_only_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_go_i |-> (busy_q && !sent_q && (t1_q == '0) && (t2_q == '0)));
  // R9
  release_on_own_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && own_bcast) |=> !busy_q);
  // R5
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !own_bcast && hit1) |=> ((t1_q == '0) && (v1_q == $past(cdb_val_i))));
endmodule

// File: rtl/rs_unit.sv
module rs_unit #(
  parameter int NUM_RS   = rs_pkg::DEF_NUM_RS,
  parameter int NUM_REGS = rs_pkg::DEF_NUM_REGS,
  parameter int DATA_W   = rs_pkg::DEF_DATA_W,
  parameter int OP_W     = rs_pkg::DEF_OP_W,
  localparam int TAG_W   = rs_pkg::tag_bits(NUM_RS),
  localparam int REG_W   = rs_pkg::idx_bits(NUM_REGS),
  localparam int IDX_W   = rs_pkg::idx_bits(NUM_RS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid_i,
  output logic                issue_ready_o,
  input  logic [OP_W-1:0]     issue_op_i,
  input  logic [REG_W-1:0]    issue_dst_i,
  input  logic [REG_W-1:0]    issue_src1_i,
  input  logic [REG_W-1:0]    issue_src2_i,
  input  logic [DATA_W-1:0]   issue_val1_i,
  input  logic [DATA_W-1:0]   issue_val2_i,
  input  logic                cdb_valid_i,
  input  logic [TAG_W-1:0]    cdb_tag_i,
  input  logic [DATA_W-1:0]   cdb_value_i,
  input  logic                fu_ready_i,
  output logic                disp_valid_o,
  output logic [TAG_W-1:0]    disp_tag_o,
  output logic [OP_W-1:0]     disp_op_o,
  output logic [DATA_W-1:0]   disp_a_o,
  output logic [DATA_W-1:0]   disp_b_o,
  output logic [NUM_REGS-1:0] reg_busy_o
);
  // tag 0 in the upper field means the lower field holds a usable value
  function automatic logic [TAG_W+DATA_W-1:0] resolve_src(
    input logic              reg_busy,
    input logic [TAG_W-1:0]  reg_tag,
    input logic [DATA_W-1:0] rf_val,
    input logic              bc_valid,
    input logic [TAG_W-1:0]  bc_tag,
    input logic [DATA_W-1:0] bc_val
  );
    if (!reg_busy)                    return {TAG_W'(0), rf_val};
    if (bc_valid && bc_tag == reg_tag) return {TAG_W'(0), bc_val};
    return {reg_tag, DATA_W'(0)};
  endfunction

  logic [NUM_RS-1:0] st_busy, st_ready, alloc_grant, disp_grant;
  logic [IDX_W-1:0]  alloc_idx, disp_idx;
  logic              alloc_any, issue_fire;
  logic [TAG_W-1:0]  alloc_tag;
  logic              r1_busy, r2_busy;
  logic [TAG_W-1:0]  r1_tag, r2_tag;
  logic [TAG_W+DATA_W-1:0] src1_res, src2_res;
  logic [OP_W-1:0]   st_op [NUM_RS];
  logic [DATA_W-1:0] st_a  [NUM_RS];
  logic [DATA_W-1:0] st_b  [NUM_RS];

  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_alloc_pick (
    .req_i(~st_busy), .grant_o(alloc_grant), .idx_o(alloc_idx), .any_o(alloc_any));

  assign issue_ready_o = alloc_any;
  assign issue_fire    = issue_valid_i && alloc_any;
  assign alloc_tag     = TAG_W'(alloc_idx) + TAG_W'(1);

  rs_tag_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(issue_fire), .wr_reg_i(issue_dst_i), .wr_tag_i(alloc_tag),
    .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i),
    .rd1_i(issue_src1_i), .rd2_i(issue_src2_i),
    .rd1_busy_o(r1_busy), .rd1_tag_o(r1_tag),
    .rd2_busy_o(r2_busy), .rd2_tag_o(r2_tag),
    .busy_o(reg_busy_o));

  assign src1_res = resolve_src(r1_busy, r1_tag, issue_val1_i, cdb_valid_i, cdb_tag_i, cdb_value_i);
  assign src2_res = resolve_src(r2_busy, r2_tag, issue_val2_i, cdb_valid_i, cdb_tag_i, cdb_value_i);

  for (genvar g = 0; g < NUM_RS; g++) begin : g_st
    rs_station #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(TAG_W'(g + 1))) u_st (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(issue_fire && alloc_grant[g]),
      .op_i(issue_op_i),
      .s1_tag_i(src1_res[TAG_W+DATA_W-1:DATA_W]), .s1_val_i(src1_res[DATA_W-1:0]),
      .s2_tag_i(src2_res[TAG_W+DATA_W-1:DATA_W]), .s2_val_i(src2_res[DATA_W-1:0]),
      .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_value_i),
      .disp_go_i(disp_grant[g] && fu_ready_i),
      .busy_o(st_busy[g]), .ready_o(st_ready[g]),
      .op_o(st_op[g]), .a_o(st_a[g]), .b_o(st_b[g]));
  end

  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_disp_pick (
    .req_i(st_ready), .grant_o(disp_grant), .idx_o(disp_idx), .any_o(disp_valid_o));

  assign disp_tag_o = TAG_W'(disp_idx) + TAG_W'(1);

  always_comb begin
    disp_op_o = '0;
    disp_a_o  = '0;
    disp_b_o  = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (disp_grant[i]) begin
        disp_op_o = disp_op_o | st_op[i];
        disp_a_o  = disp_a_o  | st_a[i];
        disp_b_o  = disp_b_o  | st_b[i];
      end
    end
  end

  // R2
  refused_issue_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_i && !issue_ready_o && !cdb_valid_i) |=> $stable(reg_busy_o));
  // R8
  lowest_ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> ((st_ready & ((NUM_RS'(1) << disp_idx) - NUM_RS'(1))) == '0));
  // R1
  disp_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> (disp_tag_o != '0));
endmodule

// File: tb/rs_unit_tb_top.sv
module rs_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [2:0]  issue_op = '0, issue_dst = '0, issue_src1 = '0, issue_src2 = '0;
  logic [15:0] issue_val1 = '0, issue_val2 = '0;
  logic        cdb_valid = 1'b0;
  logic [1:0]  cdb_tag = '0;
  logic [15:0] cdb_value = '0;
  logic        fu_ready = 1'b0;
  logic        disp_valid;
  logic [1:0]  disp_tag;
  logic [2:0]  disp_op;
  logic [15:0] disp_a, disp_b;
  logic [7:0]  reg_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rs_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .issue_op_i(issue_op), .issue_dst_i(issue_dst),
    .issue_src1_i(issue_src1), .issue_src2_i(issue_src2),
    .issue_val1_i(issue_val1), .issue_val2_i(issue_val2),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value),
    .fu_ready_i(fu_ready),
    .disp_valid_o(disp_valid), .disp_tag_o(disp_tag), .disp_op_o(disp_op),
    .disp_a_o(disp_a), .disp_b_o(disp_b), .reg_busy_o(reg_busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_done();
    @(posedge clk);
    #1;
  endtask

  task automatic set_issue(input logic [2:0] op, input logic [2:0] dst,
                           input logic [2:0] s1, input logic [2:0] s2,
                           input logic [15:0] v1, input logic [15:0] v2);
    issue_valid = 1'b1; issue_op = op; issue_dst = dst;
    issue_src1 = s1; issue_src2 = s2; issue_val1 = v1; issue_val2 = v2;
  endtask

  task automatic clear_inputs();
    issue_valid = 1'b0; cdb_valid = 1'b0; fu_ready = 1'b0;
    #1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] dst,
                       input logic [2:0] s1, input logic [2:0] s2,
                       input logic [15:0] v1, input logic [15:0] v2);
    set_issue(op, dst, s1, s2, v1, v2);
    edge_done();
    clear_inputs();
  endtask

  task automatic bcast(input logic [1:0] tag, input logic [15:0] val);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val;
    edge_done();
    clear_inputs();
  endtask

  task automatic accept();
    fu_ready = 1'b1;
    edge_done();
    clear_inputs();
  endtask

  task automatic t_reset();
    check("R11 issue_ready", issue_ready, 1);
    check("R11 disp_valid", disp_valid, 0);
    check("R11 reg_busy", reg_busy, 0);
  endtask

  task automatic t_independent();
    issue(3'd1, 3'd1, 3'd2, 3'd3, 16'd10, 16'd20);
    check("R3 disp_valid", disp_valid, 1);
    check("R1 disp_tag", disp_tag, 1);
    check("R3 disp_op", disp_op, 1);
    check("R3 disp_a", disp_a, 10);
    check("R3 disp_b", disp_b, 20);
    check("R10 dst busy", reg_busy[1], 1);
    accept();
    check("R7 not offered again", disp_valid, 0);
    bcast(2'd1, 16'd30);
    check("R10 dst cleared", reg_busy, 0);
    check("R9 all free", issue_ready, 1);
  endtask

  task automatic t_dependent();
    issue(3'd2, 3'd4, 3'd0, 3'd0, 16'd1, 16'd2);
    issue(3'd3, 3'd5, 3'd4, 3'd0, 16'hdead, 16'd7);
    check("R8 lowest ready offered", disp_tag, 1);
    accept();
    check("R4 waiting station not offered", disp_valid, 0);
    bcast(2'd1, 16'd55);
    check("R5 woken valid", disp_valid, 1);
    check("R5 woken tag", disp_tag, 2);
    check("R5 captured value", disp_a, 55);
    check("R3 second operand", disp_b, 7);
    check("R10 producer reg cleared", reg_busy, 8'h20);
    accept();
    bcast(2'd2, 16'd9);
    check("R10 all regs clear", reg_busy, 0);
  endtask

  task automatic t_forward();
    issue(3'd4, 3'd2, 3'd0, 3'd0, 16'd3, 16'd4);
    accept();
    set_issue(3'd5, 3'd6, 3'd2, 3'd0, 16'hbeef, 16'd8);
    cdb_valid = 1'b1; cdb_tag = 2'd1; cdb_value = 16'd77;
    edge_done();
    clear_inputs();
    check("R6 forwarded entry ready", disp_valid, 1);
    check("R6 forwarded entry tag", disp_tag, 2);
    check("R6 forwarded value", disp_a, 77);
    check("R6 reg status", reg_busy, 8'h40);
    accept();
    bcast(2'd2, 16'd1);
    check("R9 free after forward case", issue_ready, 1);
  endtask

  task automatic t_full();
    issue(3'd1, 3'd1, 3'd0, 3'd0, 16'd11, 16'd0);
    issue(3'd1, 3'd2, 3'd0, 3'd0, 16'd22, 16'd0);
    issue(3'd1, 3'd3, 3'd0, 3'd0, 16'd33, 16'd0);
    check("R2 stall when full", issue_ready, 0);
    issue(3'd6, 3'd7, 3'd0, 3'd0, 16'd99, 16'd0);
    check("R2 refused issue ignored", reg_busy[7], 0);
    check("R8 order first", disp_tag, 1);
    accept();
    check("R8 order second", disp_tag, 2);
    check("R8 second value", disp_a, 22);
    accept();
    check("R8 order third", disp_tag, 3);
    accept();
    check("R2 refused issue never offered", disp_valid, 0);
    bcast(2'd2, 16'd0);
    check("R9 freed station allows issue", issue_ready, 1);
    issue(3'd6, 3'd7, 3'd0, 3'd0, 16'd99, 16'd0);
    check("R8 reuse lowest free", disp_tag, 2);
    check("R9 reused station value", disp_a, 99);
    check("R10 new dst busy", reg_busy[7], 1);
    accept();
    bcast(2'd1, 16'd0);
    bcast(2'd3, 16'd0);
    bcast(2'd2, 16'd0);
    check("R10 regs clear after full", reg_busy, 0);
  endtask

  task automatic t_stale_tag();
    issue(3'd1, 3'd3, 3'd0, 3'd0, 16'd1, 16'd1);
    issue(3'd1, 3'd3, 3'd0, 3'd0, 16'd2, 16'd2);
    bcast(2'd1, 16'd5);
    check("R10 stale tag keeps busy", reg_busy[3], 1);
    bcast(2'd2, 16'd6);
    check("R10 matching tag clears", reg_busy[3], 0);
    check("R9 both freed", issue_ready, 1);
  endtask

  initial begin
    #20000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #9;
    rst_n = 1'b1;
    #2;
    t_reset();
    t_independent();
    t_dependent();
    t_forward();
    t_full();
    t_stale_tag();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule